// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is an operating-system timer. A free-running 32-bit up-counter advances on every clock cycle in which `tick_en` is high. Four compare channels each hold a 32-bit match value. When the counter holds a channel's match value at the moment it steps on, that channel's sticky status flag is set. The interrupt output for the channel is the flag gated by the channel's enable bit, and it stays high until software clears the flag.

Software reaches the registers over a plain 32-bit word bus. There is a write strobe and a 3-bit word index, where the byte offset equals four times the index. Reads are combinational. The counter can be written, and counting carries on from the loaded value. Status flags are cleared by writing ones. A sticky watchdog enable makes a channel 3 match produce a one-cycle reset pulse.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0 at all eight word indices, `irq` is 0 and `wdt_rst` is 0.
- R2: Word indices 0..3 (offsets 0x00, 0x04, 0x08, 0x0C) hold match values 0..3. These read back all 32 bits as written. Index 7 (0x1C) holds the interrupt enables in bits [3:0]. Its other bits read 0.
- R3: Index 4 (0x10) reads the counter. The counter adds one on each clock edge where `tick_en` is 1, holds otherwise, and wraps from 0xFFFFFFFF to 0.
- R4: A write to index 4 loads `bus_wdata` into the counter on that edge, taking priority over `tick_en`. A cycle that loads the counter produces no match.
- R5: If `tick_en` is 1, the counter is not being written, and the counter equals match value n, then status bit n sets on that edge. Status is read at index 5 (0x14), bits [3:0] = channels 0..3. A match value the counter has already passed sets nothing.
- R6: Writing index 5 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R7: When a status clear and a new match on the same channel fall on the same edge, the flag ends up set.
- R8: `irq[n]` equals status bit n AND enable bit n. It stays high until the flag or the enable is cleared.
- R9: Writing index 6 (0x18) with data bit 0 = 1 sets the watchdog enable, which reads back in bit 0. Writing 0 does not clear it; only reset does.
- R10: With the watchdog enable set before the edge, a channel 3 match raises `wdt_rst` for exactly one cycle, on the same edge that sets status bit 3. With the enable clear, a channel 3 match leaves `wdt_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_word` |
| irq | output | 4 | Per-channel interrupt requests |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that reset is held low for at least one edge and that the inputs carry known values from then on. They also assume that `bus_wdata` is meaningful only while `bus_wr` is high. The stimulus drives every input to a defined value before reset is released. It changes the inputs only on the falling edge. Random match values and counter loads are kept below 64 so that matches, collisions with status clears, and watchdog pulses occur often.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_wr,
  input  logic [2:0]    bus_word,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [3:0]    irq,
  output logic          wdt_rst
);
  localparam int NCH = 4;

  logic [DW-1:0]  cnt;
  logic [DW-1:0]  mval [NCH];
  logic [NCH-1:0] stat, ien, hit;
  logic           wd_en;

  wire ld_cnt = bus_wr && bus_word == 3'd4;
  wire wr_st  = bus_wr && bus_word == 3'd5;
  wire wr_wd  = bus_wr && bus_word == 3'd6;
  wire wr_ie  = bus_wr && bus_word == 3'd7;
  wire step   = tick_en && !ld_cnt;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign hit[n] = step && cnt == mval[n];

    always_ff @(posedge clk)
      if (!rst_n) mval[n] <= '0;
      else if (bus_wr && bus_word == 3'(n)) mval[n] <= bus_wdata;

    p_match_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n] |=> stat[n]);
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_st && bus_wdata[n] && !hit[n]) |=> !stat[n]);
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[n] && !(wr_st && bus_wdata[n])) |=> stat[n]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      stat    <= '0;
      ien     <= '0;
      wd_en   <= 1'b0;
      wdt_rst <= 1'b0;
    end else begin
      if (ld_cnt)       cnt <= bus_wdata;
      else if (tick_en) cnt <= cnt + 1'b1;
      stat    <= (stat & ~(wr_st ? bus_wdata[NCH-1:0] : '0)) | hit;
      if (wr_ie) ien <= bus_wdata[NCH-1:0];
      if (wr_wd && bus_wdata[0]) wd_en <= 1'b1;
      wdt_rst <= wd_en && hit[3];
    end
  end

  assign irq = stat & ien;

  always_comb
    case (bus_word)
      3'd4:    bus_rdata = cnt;
      3'd5:    bus_rdata = {{(DW-NCH){1'b0}}, stat};
      3'd6:    bus_rdata = {{(DW-1){1'b0}}, wd_en};
      3'd7:    bus_rdata = {{(DW-NCH){1'b0}}, ien};
      default: bus_rdata = mval[bus_word[1:0]];
    endcase

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_cnt) |=> cnt == $past(cnt) + 1'b1);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_cnt) |=> $stable(cnt));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> cnt == $past(bus_wdata));
  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ie && bus_wdata[NCH-1:0] == '0) |=> irq == '0);
  p_wd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> wd_en);
  p_rst_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> ($past(wd_en) && stat[3]));
  p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst && !hit[3]) |=> !wdt_rst);
endmodule

// File: tb/match_timer_tb_top.sv
`timescale 1ns/1ps
module match_timer_tb_top;
  logic        clk = 0, rst_n = 0, tick_en = 0, bus_wr = 0;
  logic [2:0]  bus_word = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0]  irq;
  logic        wdt_rst;
  int tests = 0, fails = 0;
  bit done = 0;

  match_timer dut_i (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdt_rst(wdt_rst));

  always #10 clk = ~clk;

  logic [31:0] m_cnt, m_mv [4];
  logic [3:0]  m_st, m_ie;
  logic        m_wd, m_rst;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] w);
    case (w)
      3'd4: return m_cnt;
      3'd5: return {28'd0, m_st};
      3'd6: return {31'd0, m_wd};
      3'd7: return {28'd0, m_ie};
      default: return m_mv[w[1:0]];
    endcase
  endfunction

  task automatic rd(input logic [2:0] w, input string tag);
    bus_word = w;
    #1 check(tag, bus_rdata, exp_rd(w));
  endtask

  task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d);
    logic [3:0] h;
    logic ld;
    tick_en = t; bus_wr = w; bus_word = a; bus_wdata = d;
    ld = w && a == 3'd4;
    for (int n = 0; n < 4; n++) h[n] = t && !ld && m_cnt == m_mv[n];
    @(posedge clk);
    m_rst = m_wd && h[3];
    if (w)
      case (a)
        3'd0, 3'd1, 3'd2, 3'd3: m_mv[a[1:0]] = d;
        3'd5: m_st = m_st & ~d[3:0];
        3'd6: if (d[0]) m_wd = 1'b1;
        3'd7: m_ie = d[3:0];
        default: ;
      endcase
    m_st = m_st | h;
    if (ld) m_cnt = d;
    else if (t) m_cnt = m_cnt + 1;
    @(negedge clk);
    tick_en = 0; bus_wr = 0;
    check("R8 irq", {28'd0, irq}, {28'd0, m_st & m_ie});
    check("R10 wdt_rst", {31'd0, wdt_rst}, {31'd0, m_rst});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = 0; m_st = 0; m_ie = 0; m_wd = 0; m_rst = 0;
    for (int n = 0; n < 4; n++) m_mv[n] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq", {28'd0, irq}, 0);
    check("R1 wdt_rst", {31'd0, wdt_rst}, 0);
    for (int w = 0; w < 8; w++) rd(3'(w), "R1 reset read");
    rst_n = 1;

    for (int n = 0; n < 4; n++) cyc(0, 1, 3'(n), 32'h1234_5000 + 32'(n) * 32'h1111_0000);
    cyc(0, 1, 3'd7, 32'hFFFF_FFF5);
    for (int w = 0; w < 8; w++) rd(3'(w), "R2 readback");
    cyc(0, 1, 3'd7, 0);

    cyc(0, 1, 3'd4, 32'hFFFF_FFFE);
    rd(3'd4, "R4 load");
    repeat (3) cyc(1, 0, 0, 0);
    rd(3'd4, "R3 wrap");
    check("R3 wrap value", m_cnt, 32'd1);
    cyc(0, 0, 0, 0);
    rd(3'd4, "R3 hold");

    cyc(0, 1, 3'd0, 40);
    cyc(0, 1, 3'd7, 1);
    cyc(0, 1, 3'd4, 37);
    repeat (3) cyc(1, 0, 0, 0);
    rd(3'd5, "R5 before match");
    cyc(1, 0, 0, 0);
    rd(3'd5, "R5 match");
    check("R8 irq0 high", {31'd0, irq[0]}, 1);

    cyc(0, 1, 3'd5, 0);
    rd(3'd5, "R6 zero write keeps");
    cyc(0, 1, 3'd5, 32'hE);
    rd(3'd5, "R6 other bits keep");
    cyc(0, 1, 3'd5, 1);
    rd(3'd5, "R6 clear");
    check("R8 irq0 low", {31'd0, irq[0]}, 0);

    cyc(0, 1, 3'd2, 10);
    cyc(0, 1, 3'd4, 11);
    repeat (6) cyc(1, 0, 0, 0);
    rd(3'd5, "R5 passed value");

    cyc(0, 1, 3'd1, 100);
    cyc(0, 1, 3'd4, 100);
    cyc(1, 1, 3'd4, 100);
    rd(3'd5, "R4 load blocks match");
    rd(3'd4, "R4 load priority");

    cyc(1, 1, 3'd5, 32'hF);
    rd(3'd5, "R7 match beats clear");
    check("R7 bit1", {31'd0, bus_rdata[1]}, 1);
    cyc(0, 1, 3'd5, 32'hF);

    cyc(0, 1, 3'd3, 102);
    repeat (2) cyc(1, 0, 0, 0);
    check("R10 disabled no pulse", {31'd0, wdt_rst}, 0);
    cyc(0, 1, 3'd5, 32'hF);

    cyc(0, 1, 3'd6, 1);
    rd(3'd6, "R9 set");
    cyc(0, 1, 3'd6, 0);
    rd(3'd6, "R9 sticky");
    cyc(0, 1, 3'd4, 200);
    cyc(0, 1, 3'd3, 201);
    cyc(1, 0, 0, 0);
    check("R10 no early pulse", {31'd0, wdt_rst}, 0);
    cyc(1, 0, 0, 0);
    check("R10 pulse", {31'd0, wdt_rst}, 1);
    cyc(0, 0, 0, 0);
    check("R10 one cycle", {31'd0, wdt_rst}, 0);

    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom % 16);
      if (op < 8)       cyc(1, 0, 0, 0);
      else if (op < 10) cyc($urandom % 2 == 1, 1, 3'($urandom % 4), $urandom % 64);
      else if (op < 12) cyc($urandom % 2 == 1, 1, 3'd5, $urandom);
      else if (op < 13) cyc($urandom % 2 == 1, 1, 3'd7, $urandom);
      else if (op < 15) cyc($urandom % 2 == 1, 1, 3'd4, $urandom % 64);
      else              cyc(1, 1, 3'd6, $urandom % 2);
      rd(3'($urandom % 8), "R2 R5 random read");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule